// File: doc/BRIEF.md
# Audio Serial Clock Divider Chain

This block turns a fast source clock into two slower audio timing references: a master clock and a serial bit clock. Both are produced inside the source clock domain. Each is given as a one-cycle enable pulse (`*_tick`) and as a level (`*_lvl`) that the surrounding logic can use as a gate or a clock enable.

The master clock comes from a cascade of three stages: a prescaler that divides by 1 or 8, a modulus divider of 1 to 256, and a fixed divide-by-two. The bit clock then divides the master clock further by a fine factor of 1 to 16. In direct mode the upper stages are skipped. The master clock then runs at the source rate, and the fine divider alone sets the bit clock.

Divider settings are taken only at the end of a bit-clock period, or while the block is disabled. A running period therefore always completes with the settings it started with. The transmit and receive sides each use one instance of this block.

Top module: `audclk_div_chain`

## Requirements
- R1: While `rst` is high, or in any cycle after a rising edge at which `en` was low, all four outputs are 0.
- R2: `pre_sel` = 0 sets a prescale factor P of 1, and `pre_sel` = 1 sets P = 8.
- R3: `mod_code` holds M-1, so the modulus factor M runs from 1 (code 0) to 256 (code 255).
- R4: In divided mode (`direct` = 0), the master clock period is 2·P·M source cycles. `mclk_tick` is high in the first cycle of each period, and `mclk_lvl` is high for the first P·M cycles of each period.
- R5: `fine_code` holds F-1 (F from 1 to 16). In divided mode the bit-clock period is 2·P·M·F cycles. `bclk_tick` is high in its first cycle, and `bclk_lvl` is high for its first P·M·F cycles.
- R6: Every `bclk_tick` coincides with a `mclk_tick`. The fine setting never changes the master-clock outputs.
- R7: In direct mode (`direct` = 1), `mclk_tick` and `mclk_lvl` are high in every running cycle, and `pre_sel` and `mod_code` have no effect.
- R8: In direct mode the bit-clock period is F cycles. `bclk_tick` is high in its first cycle, and `bclk_lvl` is high for the first ceil(F/2) cycles.
- R9: A change of `pre_sel`, `mod_code`, `fine_code` or `direct` while running takes effect only from the first cycle of the next bit-clock period.
- R10: After a rising edge at which `en` is first sampled high, the next cycle is the first cycle of both periods, and it uses the settings present while the block was disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low clears the counters and loads the settings |
| pre_sel | input | 1 | Prescale select: 0 divides by 1, 1 divides by PRE_DIV (8) |
| mod_code | input | MOD_W | Modulus divider, value minus one |
| fine_code | input | FINE_W | Fine bit-clock divider, value minus one |
| direct | input | 1 | Bypass prescaler, modulus and divide-by-two for the master clock |
| mclk_tick | output | 1 | One-cycle pulse at the start of each master clock period |
| mclk_lvl | output | 1 | Master clock level, high in the first half period |
| bclk_tick | output | 1 | One-cycle pulse at the start of each bit clock period |
| bclk_lvl | output | 1 | Bit clock level, high in the first part of the period |

## Verification
The range and hold assertions assume two things about the settings. First, they are loaded only at a period boundary or while `en` is low. Second, `rst` is held high for at least one edge before `en` rises, so that every counter starts from zero. The stimulus changes settings mid-period only in the sections that exercise deferred loading. It always starts a run from a disabled state and drops `en` between sweep points, so each new run starts cleanly from the origin. A cycle model in the bench follows the same boundary rule arithmetically, so settings changed mid-run are checked against the period in which they should first appear.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  // Last value of the fine counter before it wraps.
  // Divided mode counts master half-periods (2F of them); direct mode counts source cycles (F).
  function automatic int fine_last(input bit dir, input int code);
    return dir ? code : (2 * code + 1);
  endfunction

  // Last fine-counter value during which the bit clock level stays high.
  // Divided mode: F half-periods high. Direct mode: ceil(F/2) cycles high.
  function automatic int bclk_high_last(input bit dir, input int code);
    return dir ? (code / 2) : code;
  endfunction

  // Source cycles in one master half-period for a given prescale/modulus setting.
  function automatic int half_len(input bit pre8, input int pre_div, input int mcode);
    return (pre8 ? pre_div : 1) * (mcode + 1);
  endfunction

endpackage

// File: rtl/audclk_upper_div.sv
module audclk_upper_div #(
  parameter int PRE_DIV = 8,
  parameter int MOD_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic             pre_sel,
  input  logic [MOD_W-1:0] mod_last,
  output logic             wrap,
  output logic             origin
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic             pre_done;
  logic             pre_zero;
  logic [MOD_W-1:0] mcnt;
  logic             mod_done;

  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] pcnt;
      logic [PRE_W-1:0] plim;

      assign plim     = pre_sel ? PRE_W'(PRE_DIV - 1) : '0;
      assign pre_done = (pcnt == plim);
      assign pre_zero = (pcnt == '0);

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          pcnt <= '0;
        end else if (adv) begin
          pcnt <= pre_done ? '0 : pcnt + 1'b1;
        end
      end

      // R2: prescale counter never passes its selected limit
      assert_pcnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        adv |-> (pcnt <= plim));
    end else begin : g_nopre
      assign pre_done = 1'b1;
      assign pre_zero = 1'b1;
    end
  endgenerate

  assign mod_done = (mcnt == mod_last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mcnt <= '0;
    end else if (adv && pre_done) begin
      mcnt <= mod_done ? '0 : mcnt + 1'b1;
    end
  end

  assign wrap   = pre_done && mod_done;
  assign origin = pre_zero && (mcnt == '0);

  // R3: modulus counter stays within the programmed range
  assert_mcnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    adv |-> (mcnt <= mod_last));

endmodule

// File: rtl/audclk_fine_div.sv
module audclk_fine_div #(
  parameter int FINE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  logic              dir,
  input  logic [FINE_W-1:0] fine_code,
  output logic [FINE_W:0]   fcnt,
  output logic              fterm
);
  localparam int FCW = FINE_W + 1;

  logic [FCW-1:0] top;

  assign top   = FCW'(audclk_pkg::fine_last(dir, int'(fine_code)));
  assign fterm = step && (fcnt == top);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fcnt <= '0;
    end else if (step) begin
      fcnt <= fterm ? '0 : fcnt + 1'b1;
    end
  end

  // R5: fine counter never exceeds the last value for the active setting
  assert_fcnt_range_R5: assert property (@(posedge clk) disable iff (rst)
    !clr |-> (fcnt <= top));

endmodule

// File: rtl/audclk_out_gen.sv
module audclk_out_gen #(
  parameter int FINE_W = 4
) (
  input  logic              run,
  input  logic              dir,
  input  logic              origin,
  input  logic [FINE_W:0]   fcnt,
  input  logic [FINE_W-1:0] fine_code,
  output logic              mclk_tick,
  output logic              mclk_lvl,
  output logic              bclk_tick,
  output logic              bclk_lvl
);
  localparam int FCW = FINE_W + 1;

  logic [FCW-1:0] hi_last;
  logic           first_half;

  assign hi_last    = FCW'(audclk_pkg::bclk_high_last(dir, int'(fine_code)));
  assign first_half = ~fcnt[0];

  assign mclk_tick = run & (dir | (origin & first_half));
  assign mclk_lvl  = run & (dir | first_half);
  assign bclk_tick = run & origin & (fcnt == '0);
  assign bclk_lvl  = run & (fcnt <= hi_last);

endmodule

// File: rtl/audclk_div_chain.sv
module audclk_div_chain #(
  parameter int PRE_DIV = 8,
  parameter int MOD_W   = 8,
  parameter int FINE_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              pre_sel,
  input  logic [MOD_W-1:0]  mod_code,
  input  logic [FINE_W-1:0] fine_code,
  input  logic              direct,
  output logic              mclk_tick,
  output logic              mclk_lvl,
  output logic              bclk_tick,
  output logic              bclk_lvl
);
  localparam int FCW = FINE_W + 1;

  // active (latched) settings
  logic              run;
  logic              act_pre;
  logic              act_dir;
  logic [MOD_W-1:0]  act_mod;
  logic [FINE_W-1:0] act_fine;

  // internal events, named for the assertions
  logic           up_adv;
  logic           up_wrap;
  logic           up_origin;
  logic           step;
  logic           fterm;
  logic           latch_cfg;
  logic           cnt_clr;
  logic [FCW-1:0] fcnt;

  assign cnt_clr   = ~en;
  assign up_adv    = run & en & ~act_dir;
  assign step      = run & en & (act_dir | up_wrap);
  assign latch_cfg = ~en | fterm;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      act_pre  <= 1'b0;
      act_dir  <= 1'b0;
      act_mod  <= '0;
      act_fine <= '0;
    end else begin
      run <= en;
      if (latch_cfg) begin
        act_pre  <= pre_sel;
        act_dir  <= direct;
        act_mod  <= mod_code;
        act_fine <= fine_code;
      end
    end
  end

  audclk_upper_div #(.PRE_DIV(PRE_DIV), .MOD_W(MOD_W)) u_upper (
    .clk      (clk),
    .rst      (rst),
    .clr      (cnt_clr),
    .adv      (up_adv),
    .pre_sel  (act_pre),
    .mod_last (act_mod),
    .wrap     (up_wrap),
    .origin   (up_origin)
  );

  audclk_fine_div #(.FINE_W(FINE_W)) u_fine (
    .clk       (clk),
    .rst       (rst),
    .clr       (cnt_clr),
    .step      (step),
    .dir       (act_dir),
    .fine_code (act_fine),
    .fcnt      (fcnt),
    .fterm     (fterm)
  );

  audclk_out_gen #(.FINE_W(FINE_W)) u_out (
    .run       (run),
    .dir       (act_dir),
    .origin    (up_origin),
    .fcnt      (fcnt),
    .fine_code (act_fine),
    .mclk_tick (mclk_tick),
    .mclk_lvl  (mclk_lvl),
    .bclk_tick (bclk_tick),
    .bclk_lvl  (bclk_lvl)
  );

  // R1: nothing leaves the block while it is idle
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
    !run |-> !(mclk_tick | mclk_lvl | bclk_tick | bclk_lvl));

  // R4: a master pulse only ever opens a high half-period
  assert_mtick_level_R4: assert property (@(posedge clk) disable iff (rst)
    mclk_tick |-> mclk_lvl);

  // R5: a bit-clock pulse only ever opens a high phase
  assert_btick_level_R5: assert property (@(posedge clk) disable iff (rst)
    bclk_tick |-> bclk_lvl);

  // R6: bit-clock periods start on master-clock period starts
  assert_bclk_on_mclk_R6: assert property (@(posedge clk) disable iff (rst)
    bclk_tick |-> mclk_tick);

  // R7: direct mode passes the source rate straight through
  assert_direct_mclk_R7: assert property (@(posedge clk) disable iff (rst)
    (run && act_dir) |-> (mclk_tick && mclk_lvl));

  // R9: settings only move at a period boundary or while disabled
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(fterm)) |->
      ($stable(act_mod) && $stable(act_fine) && $stable(act_pre) && $stable(act_dir)));

  // R10: the first running cycle starts both periods
  assert_start_tick_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (bclk_tick && mclk_tick));

endmodule

// File: tb/sim_audclk_div_chain.sv
module sim_audclk_div_chain;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       pre_sel = 1'b0;
  logic       direct = 1'b0;
  logic [7:0] mod_code = '0;
  logic [3:0] fine_code = '0;
  logic       mclk_tick, mclk_lvl, bclk_tick, bclk_lvl;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    chk_on = 1'b0;
  string ph_tag = "";

  // cycle model state
  int m_run = 0, m_pos = 0;
  int a_pre = 0, a_mod = 0, a_fine = 0, a_dir = 0;

  always #10 clk = ~clk;  // 50 MHz

  audclk_div_chain #(.PRE_DIV(8), .MOD_W(8), .FINE_W(4)) u0 (
    .clk(clk), .rst(rst), .en(en), .pre_sel(pre_sel), .mod_code(mod_code),
    .fine_code(fine_code), .direct(direct), .mclk_tick(mclk_tick),
    .mclk_lvl(mclk_lvl), .bclk_tick(bclk_tick), .bclk_lvl(bclk_lvl)
  );

  function automatic int hlen(int p, int m);
    int pf;
    pf = (p != 0) ? 8 : 1;
    return pf * (m + 1);
  endfunction

  function automatic int bper(int p, int m, int f, int d);
    if (d != 0) return f + 1;
    return 2 * hlen(p, m) * (f + 1);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // model update and watchdog on the active edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_run = 0; m_pos = 0; a_pre = 0; a_mod = 0; a_fine = 0; a_dir = 0;
    end else if (!en) begin
      m_run = 0; m_pos = 0;
      a_pre = int'(pre_sel); a_mod = int'(mod_code); a_fine = int'(fine_code); a_dir = int'(direct);
    end else if (m_run == 0) begin
      m_run = 1; m_pos = 0;
    end else if (m_pos == bper(a_pre, a_mod, a_fine, a_dir) - 1) begin
      m_pos = 0;
      a_pre = int'(pre_sel); a_mod = int'(mod_code); a_fine = int'(fine_code); a_dir = int'(direct);
    end else begin
      m_pos++;
    end
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      finish_up();
    end
  end

  // compare outputs with the model away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      int em_t, em_l, eb_t, eb_l, h, mp;
      string tm, tb;
      if (m_run == 0) begin
        em_t = 0; em_l = 0; eb_t = 0; eb_l = 0; tm = "R1"; tb = "R1";
      end else if (a_dir != 0) begin
        em_t = 1; em_l = 1;
        eb_t = (m_pos == 0) ? 1 : 0;
        eb_l = (m_pos < (a_fine + 2) / 2) ? 1 : 0;
        tm = "R7"; tb = "R8";
      end else begin
        h  = hlen(a_pre, a_mod);
        mp = m_pos % (2 * h);
        em_t = (mp == 0) ? 1 : 0;
        em_l = (mp < h) ? 1 : 0;
        eb_t = (m_pos == 0) ? 1 : 0;
        eb_l = (m_pos < h * (a_fine + 1)) ? 1 : 0;
        tm = "R4 R6"; tb = "R5";
      end
      if (m_run != 0 && ph_tag != "") begin tm = ph_tag; tb = ph_tag; end
      chk(tm, "mclk_tick", int'(mclk_tick), em_t);
      chk(tm, "mclk_lvl",  int'(mclk_lvl),  em_l);
      chk(tb, "bclk_tick", int'(bclk_tick), eb_t);
      chk(tb, "bclk_lvl",  int'(bclk_lvl),  eb_l);
    end
  end

  task automatic set_cfg(int p, int m, int f, int d);
    pre_sel = p[0]; mod_code = m[7:0]; fine_code = f[3:0]; direct = d[0];
  endtask

  // start from disabled, run ncyc cycles, optionally measure the master period
  task automatic run_cfg(int p, int m, int f, int d, int ncyc, bit meas, string mtag);
    int first, second;
    @(negedge clk);
    en = 1'b0;
    set_cfg(p, m, f, d);
    repeat (2) @(negedge clk);
    en = 1'b1;
    first = -1; second = -1;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (mclk_tick) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
    end
    if (meas) chk(mtag, "mclk period", second - first, 2 * hlen(p, m));
    en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_on = 1'b1;
    // R1: reset state
    chk("R1", "mclk_tick in reset", int'(mclk_tick), 0);
    chk("R1", "mclk_lvl in reset",  int'(mclk_lvl),  0);
    chk("R1", "bclk_tick in reset", int'(bclk_tick), 0);
    chk("R1", "bclk_lvl in reset",  int'(bclk_lvl),  0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R2 R3 R4 R5 R6: divided-mode sweep
    for (int p = 0; p < 2; p++) begin
      for (int mi = 0; mi < 5; mi++) begin
        for (int f = 0; f < 16; f++) begin
          int mv;
          mv = (mi == 4) ? 7 : mi;
          run_cfg(p, mv, f, 0, bper(p, mv, f, 0) + 3, 1'b1, "R2 R3");
        end
      end
    end
    // R3: top of the modulus range
    run_cfg(1, 255, 1, 0, bper(1, 255, 1, 0) + 3, 1'b1, "R3");

    // R7 R8: direct mode, prescaler and modulus set to values that must be ignored
    for (int f = 0; f < 16; f++) begin
      run_cfg(f % 2, 37 + 11 * f, f, 1, 2 * (f + 1) + 3, 1'b0, "R7");
    end

    // R9: settings changed while running apply at the next bit-clock boundary
    ph_tag = "R9";
    @(negedge clk); en = 1'b0; set_cfg(0, 2, 2, 0);
    repeat (2) @(negedge clk); en = 1'b1;
    repeat (7) @(negedge clk); set_cfg(0, 1, 1, 0);
    repeat (30) @(negedge clk); set_cfg(1, 5, 3, 1);
    repeat (20) @(negedge clk); set_cfg(1, 0, 0, 0);
    repeat (40) @(negedge clk); en = 1'b0;
    repeat (2) @(negedge clk);

    // R10: disable mid-period, reload, restart from the origin
    ph_tag = "R10";
    set_cfg(0, 3, 3, 0);
    @(negedge clk); en = 1'b1;
    repeat (20) @(negedge clk);
    en = 1'b0; set_cfg(0, 0, 0, 0);
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    chk("R10", "first bclk_tick after enable", int'(bclk_tick), 1);
    chk("R10", "first mclk_tick after enable", int'(mclk_tick), 1);
    repeat (10) @(negedge clk);
    ph_tag = "";

    // R1: reset while running
    set_cfg(0, 1, 2, 0);
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "mclk_lvl after reset", int'(mclk_lvl), 0);
    chk("R1", "bclk_lvl after reset", int'(bclk_lvl), 0);
    en = 1'b0; rst = 1'b0;
    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule